// File: doc/BRIEF.md
# Serial-to-Vector Grouping Unit

This block takes one data word on every clock cycle and packs consecutive words into groups of `GROUP_K` elements. While a group is still filling, the output is flagged absent. When the last word of a group arrives, that word is combined in the same cycle with the words already held, and the whole vector is presented together with a valid flag.

A new group starts on the cycle after an emission, so there is never an idle cycle between groups. The block has no input qualifier and no backpressure, so every clock edge out of reset consumes one word. Both the group size and the element width are parameters. A group size of one is supported: in that case every word passes straight through as a one-element vector.

Top module: `vec_gather`

## Requirements
- R1: While `rst_ni` is low, `vec_valid_o` is 0 and `vec_o` is all zeros, for any group size.
- R2: Number the words sampled since reset release from 0. For `GROUP_K` of at least 2, `vec_valid_o` is 1 exactly in the cycles where that number modulo `GROUP_K` equals `GROUP_K-1`, and 0 in every other cycle.
- R3: The final element of an emitted vector is the value on `word_i` in that same cycle. A change of `word_i` within the cycle shows on `vec_o` without waiting for a clock edge.
- R4: Element i of an emitted vector sits at bits `[i*ELEM_W +: ELEM_W]`. Element 0 is the earliest word of the group and higher indices hold later words.
- R5: In every cycle where `vec_valid_o` is 0, `vec_o` is all zeros.
- R6: The word sampled in the cycle right after an emission becomes element 0 of the next group. Successive groups are contiguous and do not overlap.
- R7: Asserting reset in the middle of a group discards the partly filled group. After release, the next `GROUP_K` words form a complete group.
- R8: With `GROUP_K` equal to 1, every cycle out of reset has `vec_valid_o` at 1 and `vec_o` equal to `word_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; state advances on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| word_i | input | ELEM_W | Incoming data word, consumed every cycle |
| vec_valid_o | output | 1 | High when `vec_o` carries a complete group |
| vec_o | output | ELEM_W*GROUP_K | Assembled group, element 0 in the low bits |

## Verification
A fill count that has drifted moves the valid pulse off its place in the group-size cadence. The error therefore appears within one group length, either as a missing pulse or as an extra one. A slot written at the wrong moment leaves the cadence intact but puts a stale or repeated word into the next emitted vector. A wrong slot mapping puts elements in the wrong order. Both of these become visible at the first emission after the fault. A missing clear shows as nonzero data in an absent cycle straight away.

// File: rtl/vg_pkg.sv
package vg_pkg;

  typedef enum logic [1:0] {
    PH_OPEN  = 2'd0,
    PH_FILL  = 2'd1,
    PH_CLOSE = 2'd2,
    PH_SOLO  = 2'd3
  } phase_e;

  function automatic int cnt_bits(input int k);
    return (k < 1) ? 1 : $clog2(k + 1);
  endfunction

endpackage

// File: rtl/vg_fill_ctrl.sv
module vg_fill_ctrl #(
  parameter int K     = 4,
  parameter int CW    = 3,
  parameter int SLOTS = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [CW-1:0]      cnt_o,
  output vg_pkg::phase_e     phase_o,
  output logic [SLOTS-1:0]   slot_we_o
);

  localparam logic [CW-1:0] FULL = CW'(K);
  localparam logic [CW-1:0] LAST = CW'(K - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0]  cnt_q, cnt_d;
  logic           cnt_en;
  vg_pkg::phase_e phase;

  // Decode where the stored group stands
  always_comb begin
    if (K == 1)                              phase = vg_pkg::PH_SOLO;
    else if (cnt_q == '0 || cnt_q == FULL)   phase = vg_pkg::PH_OPEN;
    else if (cnt_q == LAST)                  phase = vg_pkg::PH_CLOSE;
    else                                     phase = vg_pkg::PH_FILL;
  end

  // Next fill count: a fresh group holds one word, otherwise grow by one
  always_comb begin
    if (phase == vg_pkg::PH_OPEN || phase == vg_pkg::PH_SOLO) cnt_d = ONE;
    else                                                      cnt_d = cnt_q + ONE;
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // One write enable per storage slot
  for (genvar i = 0; i < SLOTS; i++) begin : g_we
    always_comb begin
      slot_we_o[i] = 1'b0;
      if (phase == vg_pkg::PH_OPEN && i == 0)                    slot_we_o[i] = 1'b1;
      else if (phase == vg_pkg::PH_FILL && cnt_q == CW'(i))      slot_we_o[i] = 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign phase_o = phase;

endmodule

// File: rtl/vg_slot_bank.sv
module vg_slot_bank #(
  parameter int W     = 8,
  parameter int SLOTS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SLOTS-1:0]     we_i,
  input  logic [W-1:0]         word_i,
  output logic [W*SLOTS-1:0]   slots_o
);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [W-1:0] q, d;

    always_comb begin
      d = q;
      if (we_i[i]) d = word_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (we_i[i]) q <= d;
    end

    assign slots_o[i*W +: W] = q;
  end

endmodule

// File: rtl/vg_out_mux.sv
module vg_out_mux #(
  parameter int W     = 8,
  parameter int K     = 4,
  parameter int SLOTS = 3
) (
  input  logic               live_i,
  input  vg_pkg::phase_e     phase_i,
  input  logic [W-1:0]       word_i,
  input  logic [W*SLOTS-1:0] slots_i,
  output logic               valid_o,
  output logic [W*K-1:0]     vec_o
);

  logic close;
  assign close   = live_i && (phase_i == vg_pkg::PH_CLOSE || phase_i == vg_pkg::PH_SOLO);
  assign valid_o = close;

  if (K == 1) begin : g_single
    logic unused_slots;
    assign unused_slots = ^slots_i;
    assign vec_o = close ? word_i : '0;
  end else begin : g_multi
    assign vec_o = close ? {word_i, slots_i[W*(K-1)-1:0]} : '0;
  end

endmodule

// File: rtl/vec_gather.sv
module vec_gather #(
  parameter int ELEM_W  = 8,
  parameter int GROUP_K = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ELEM_W-1:0]         word_i,
  output logic                      vec_valid_o,
  output logic [ELEM_W*GROUP_K-1:0] vec_o
);

  localparam int CW    = vg_pkg::cnt_bits(GROUP_K);
  localparam int SLOTS = (GROUP_K > 1) ? GROUP_K - 1 : 1;

  logic [CW-1:0]          fill_cnt;
  vg_pkg::phase_e         phase;
  logic [SLOTS-1:0]       slot_we;
  logic [ELEM_W*SLOTS-1:0] slots;

  vg_fill_ctrl #(.K(GROUP_K), .CW(CW), .SLOTS(SLOTS)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_o     (fill_cnt),
    .phase_o   (phase),
    .slot_we_o (slot_we)
  );

  vg_slot_bank #(.W(ELEM_W), .SLOTS(SLOTS)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (slot_we),
    .word_i  (word_i),
    .slots_o (slots)
  );

  vg_out_mux #(.W(ELEM_W), .K(GROUP_K), .SLOTS(SLOTS)) u_mux (
    .live_i  (rst_ni),
    .phase_i (phase),
    .word_i  (word_i),
    .slots_i (slots),
    .valid_o (vec_valid_o),
    .vec_o   (vec_o)
  );

endmodule

// File: rtl/vec_gather_chk.sv
module vec_gather_chk #(
  parameter int W  = 8,
  parameter int K  = 4,
  parameter int CW = 3
) (
  input logic           clk,
  input logic           rst_ni,
  input logic [W-1:0]   word,
  input logic           valid,
  input logic [W*K-1:0] vec,
  input logic [CW-1:0]  cnt
);

  // Independent cadence model: position of the current word in its group
  logic [CW-1:0] pos;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                 pos <= '0;
    else if (pos == CW'(K - 1))  pos <= '0;
    else                         pos <= pos + CW'(1);
  end

  p_emit_cadence_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    valid == (pos == CW'(K - 1)));

  p_last_is_live_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    valid |-> vec[W*K-1 -: W] == word);

  p_absent_clear_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    !valid |-> vec == '0);

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt <= CW'(K));

  if (K >= 2) begin : g_order
    p_prev_elem_r4: assert property (@(posedge clk) disable iff (!rst_ni)
      valid |-> vec[W*(K-2) +: W] == $past(word));
  end else begin : g_solo
    p_every_cycle_r8: assert property (@(posedge clk) disable iff (!rst_ni)
      valid);
  end

  always_comb begin
    if (!rst_ni) begin
      a_reset_quiet_r1: assert (!valid || $isunknown(valid));
    end
  end

endmodule

bind vec_gather vec_gather_chk #(.W(ELEM_W), .K(GROUP_K), .CW(CW)) u_chk (
  .clk    (clk_i),
  .rst_ni (rst_ni),
  .word   (word_i),
  .valid  (vec_valid_o),
  .vec    (vec_o),
  .cnt    (fill_cnt)
);

// File: tb/vec_gather_tb.sv
module vec_gather_tb;

  localparam int PERIOD = 10;
  localparam int W      = 8;
  localparam int K      = 4;
  localparam int NROWS  = 12;

  // row = {word, expected valid, expected vector}
  localparam logic [W+1+W*K-1:0] TBL [NROWS] = '{
    {8'hA5, 1'b0, 32'h0},
    {8'h5A, 1'b0, 32'h0},
    {8'h00, 1'b0, 32'h0},
    {8'hFF, 1'b1, 32'hFF005AA5},
    {8'h01, 1'b0, 32'h0},
    {8'h02, 1'b0, 32'h0},
    {8'h03, 1'b0, 32'h0},
    {8'h04, 1'b1, 32'h04030201},
    {8'h80, 1'b0, 32'h0},
    {8'h7F, 1'b0, 32'h0},
    {8'hC3, 1'b0, 32'h0},
    {8'h3C, 1'b1, 32'h3CC37F80}
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic [W-1:0]   word, word1;
  logic           vld, vld1;
  logic [W*K-1:0] vec;
  logic [W-1:0]   vec1;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(PERIOD/2) clk = ~clk;

  vec_gather #(.ELEM_W(W), .GROUP_K(K)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .vec_valid_o(vld), .vec_o(vec));

  vec_gather #(.ELEM_W(W), .GROUP_K(1)) u_dut_single (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word1), .vec_valid_o(vld1), .vec_o(vec1));

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    word  = 8'h00;
    word1 = 8'h00;
    repeat (3) @(negedge clk);
    word = 8'h77; word1 = 8'h66;
    #(PERIOD/4);
    chk("R1", {vld, vec}, 33'h0);
    chk("R1", {vld1, 24'h0, vec1}, 33'h0);

    // Release at a negedge together with the first table word
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NROWS; i++) begin
      word  = TBL[i][W+W*K];
      word  = TBL[i][W+1+W*K-1 -: W];
      word1 = ~TBL[i][W+1+W*K-1 -: W];
      #(PERIOD/4);
      if (TBL[i][W*K])
        chk((i < 4) ? "R4" : "R6", {vld, vec}, {1'b1, TBL[i][W*K-1:0]});
      else begin
        chk("R2", {32'h0, vld}, 33'h0);
        chk("R5", {1'b0, vec}, 33'h0);
      end
      chk("R8", {vld1, 24'h0, vec1}, {1'b1, 24'h0, word1});
      if (i == NROWS - 1) begin
        word = 8'h99;
        #1;
        chk("R3", {vld, vec}, {1'b1, 32'h99C37F80});
      end
      @(negedge clk);
    end

    // Partial group then reset in the middle of it
    word = 8'hAA; #(PERIOD/4); chk("R6", {vld, vec}, 33'h0); @(negedge clk);
    word = 8'hBB; #(PERIOD/4); chk("R7", {vld, vec}, 33'h0); @(negedge clk);
    rst_n = 1'b0;
    word  = 8'hEE;
    #(PERIOD/4);
    chk("R1", {vld1, 24'h0, vec1}, 33'h0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int j = 0; j < K; j++) begin
      word = 8'hD1 + 8'(j);
      #(PERIOD/4);
      if (j == K - 1) chk("R7", {vld, vec}, {1'b1, 32'hD4D3D2D1});
      else            chk("R7", {vld, vec}, 33'h0);
      @(negedge clk);
    end

    // Next group follows with no gap
    for (int j = 0; j < K; j++) begin
      word = 8'h40 + 8'(j);
      #(PERIOD/4);
      if (j == K - 1) chk("R6", {vld, vec}, {1'b1, 32'h43424140});
      else            chk("R2", {32'h0, vld}, 33'h0);
      @(negedge clk);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule